// File: doc/BRIEF.md
# Adjustable Nanosecond Time Counter

This block keeps a free-running time-of-day count for packet timestamping. On every reference clock edge it adds a programmable nominal increment to the count. It can also use a second programmable increment in place of the nominal one on a fixed cadence of cycles. Choosing that increment and cadence trims the average rate finely, for example to follow a remote clock.

The count can run across the full register width. It can also fold back at a programmable period, so that, for example, a period of 2^31 gives a 31-bit timer. A fold (or a carry out of the full width) can raise a single-cycle event for compare channels attached downstream.

Software reaches the counter through a small register bus with a write strobe, an address and write data, and a combinational read port. Through this bus it can start and stop counting, restart the count at zero, load a new count, and request a snapshot of the running count into a readable register. The live count is also presented on a port for timestamp logic.

Top module: `nstime_counter`

## Requirements
- R1: After reset the count is 0, the event output is low, and every register reads as 0.
- R2: With control bit 0 set, each cycle adds the nominal increment (increment register, address 4, bits 6:0). With control bit 0 clear, the count holds.
- R3: When the correction period register (address 3) holds P > 0 and the correction increment (address 4, bits 14:8) is nonzero, every (P+1)-th advancing cycle adds the correction increment instead of the nominal one. The phase is counted from the cycle the correction became active or from the last restart.
- R4: A correction period of 0 or a correction increment of 0 disables correction, and every advancing cycle then uses the nominal increment.
- R5: With control bits 5:4 = 11 and a nonzero period register (address 2), a step whose sum reaches or passes the period leaves the count at the sum minus the period.
- R6: Otherwise the count wraps modulo 2^CNT_W, and a carry out of the top bit counts as a wrap.
- R7: With control bit 7 set, a wrap drives the event output high for exactly the cycle in which the wrapped count is shown. With bit 7 clear, the event output stays low.
- R8: Writing control (address 0) with bit 9 set forces the count to 0 and the correction phase to 0 at that edge. Bit 9 is not stored and reads as 0.
- R9: Writing control with bit 11 set copies the count one edge later into the time register (address 1, read side). Bit 11 reads as 1 until that copy is taken, then clears by itself.
- R10: Writing the time register (address 1) loads the count with the write data at that edge, in place of any increment.
- R11: A wrap does not reset the correction phase, and a correction step that causes a wrap is folded like any other step.
- R12: The period, correction period and increment registers read back as written. Control reads back bits 0, 5:4 and 7 as written, plus the pending capture flag in bit 11. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (0 control, 1 time, 2 period, 3 correction period, 4 increment) |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| count_o | output | CNT_W | Live count |
| wrap_evt_o | output | 1 | Wrap event pulse toward compare channels |

## Verification
A register write or a counting step shows on count_o and wrap_evt_o right after the clock edge that samples it. A snapshot request shows in the time register one edge later. Read data is combinational, so it reflects the state before the next edge. The bench drives each bus cycle after a falling edge and samples the read port a nanosecond later. It then lets one rising edge pass, advances its own model by that one edge, and compares count and event at the following falling edge. This keeps every comparison aligned to the cycle in which the result is due.

// File: rtl/tc_pkg.sv
package tc_pkg;
   // register word addresses
   localparam logic [2:0] TC_CTRL   = 3'd0;
   localparam logic [2:0] TC_TIME   = 3'd1;
   localparam logic [2:0] TC_PERIOD = 3'd2;
   localparam logic [2:0] TC_CPER   = 3'd3;
   localparam logic [2:0] TC_INC    = 3'd4;
   // control bit positions
   localparam int CB_EN      = 0;
   localparam int CB_MODE    = 4;
   localparam int CB_EVT     = 7;
   localparam int CB_RESTART = 9;
   localparam int CB_CAPTURE = 11;
   // increment register field
   localparam int INC_CORR_LSB = 8;
   localparam logic [1:0] MODE_PERIOD = 2'b11;
endpackage

// File: rtl/tc_regs.sv
module tc_regs
   import tc_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int INC_W  = 7,
   parameter int CPER_W = 16,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic [DATA_W-1:0] rdata,
   output logic              en_o,
   output logic              pmode_o,
   output logic              evt_en_o,
   output logic [CNT_W-1:0]  period_o,
   output logic [CPER_W-1:0] cper_o,
   output logic [INC_W-1:0]  ninc_o,
   output logic [INC_W-1:0]  cinc_o,
   output logic              restart_o,
   output logic              load_o
);
   logic             en_q, evt_q, pend_q;
   logic [1:0]       mode_q;
   logic [CNT_W-1:0] period_q, snap_q;
   logic [CPER_W-1:0] cper_q;
   logic [INC_W-1:0] ninc_q, cinc_q;
   logic             wr_ctrl, wr_time, wr_per, wr_cper, wr_inc;

   assign wr_ctrl = we && (addr == ADDR_W'(TC_CTRL));
   assign wr_time = we && (addr == ADDR_W'(TC_TIME));
   assign wr_per  = we && (addr == ADDR_W'(TC_PERIOD));
   assign wr_cper = we && (addr == ADDR_W'(TC_CPER));
   assign wr_inc  = we && (addr == ADDR_W'(TC_INC));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         evt_q    <= 1'b0;
         mode_q   <= 2'b00;
         pend_q   <= 1'b0;
         snap_q   <= '0;
         period_q <= '0;
         cper_q   <= '0;
         ninc_q   <= '0;
         cinc_q   <= '0;
      end else begin
         if (pend_q) snap_q <= cnt_i;
         pend_q <= wr_ctrl && wdata[CB_CAPTURE];
         if (wr_ctrl) begin
            en_q   <= wdata[CB_EN];
            mode_q <= wdata[CB_MODE+1:CB_MODE];
            evt_q  <= wdata[CB_EVT];
         end
         if (wr_per)  period_q <= wdata[CNT_W-1:0];
         if (wr_cper) cper_q   <= wdata[CPER_W-1:0];
         if (wr_inc) begin
            ninc_q <= wdata[INC_W-1:0];
            cinc_q <= wdata[INC_CORR_LSB +: INC_W];
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_W'(TC_CTRL): begin
            rdata[CB_EN]               = en_q;
            rdata[CB_MODE+1:CB_MODE]   = mode_q;
            rdata[CB_EVT]              = evt_q;
            rdata[CB_CAPTURE]          = pend_q;
         end
         ADDR_W'(TC_TIME):   rdata[CNT_W-1:0]  = snap_q;
         ADDR_W'(TC_PERIOD): rdata[CNT_W-1:0]  = period_q;
         ADDR_W'(TC_CPER):   rdata[CPER_W-1:0] = cper_q;
         ADDR_W'(TC_INC): begin
            rdata[INC_W-1:0]            = ninc_q;
            rdata[INC_CORR_LSB +: INC_W] = cinc_q;
         end
         default: rdata = '0;
      endcase
   end

   assign en_o      = en_q;
   assign pmode_o   = (mode_q == MODE_PERIOD);
   assign evt_en_o  = evt_q;
   assign period_o  = period_q;
   assign cper_o    = cper_q;
   assign ninc_o    = ninc_q;
   assign cinc_o    = cinc_q;
   assign restart_o = wr_ctrl && wdata[CB_RESTART];
   assign load_o    = wr_time;
endmodule

// File: rtl/tc_corr.sv
module tc_corr #(
   parameter int CPER_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv_i,
   input  logic              restart_i,
   input  logic [CPER_W-1:0] cper_i,
   input  logic              cinc_nz_i,
   output logic              hit_o
);
   logic [CPER_W-1:0] phase_q;
   logic              active;

   assign active = (cper_i != '0) && cinc_nz_i;
   assign hit_o  = active && adv_i && (phase_q == cper_i);

   always_ff @(posedge clk) begin
      if (!rst_n)          phase_q <= '0;
      else if (restart_i)  phase_q <= '0;
      else if (!active)    phase_q <= '0;
      else if (adv_i)      phase_q <= hit_o ? '0 : phase_q + 1'b1;
   end
endmodule

// File: rtl/tc_accum.sv
module tc_accum #(
   parameter int CNT_W       = 32,
   parameter int INC_W       = 7,
   parameter bit PERIOD_WRAP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             restart_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             pmode_i,
   input  logic [CNT_W-1:0] period_i,
   input  logic             evt_en_i,
   input  logic [INC_W-1:0] step_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_evt_o
);
   localparam int SUM_W = CNT_W + 1;

   logic [CNT_W-1:0] cnt_q, nxt;
   logic             evt_q, wrapped;
   logic [SUM_W-1:0] sum;

   assign sum = {1'b0, cnt_q} + {{(SUM_W-INC_W){1'b0}}, step_i};

   if (PERIOD_WRAP) begin : g_period
      logic             per_on, ge;
      logic [SUM_W-1:0] red;
      always_comb begin
         per_on = pmode_i && (period_i != '0);
         ge     = (sum >= {1'b0, period_i});
         red    = sum - {1'b0, period_i};
         if (per_on) begin
            wrapped = ge;
            nxt     = ge ? red[CNT_W-1:0] : sum[CNT_W-1:0];
         end else begin
            wrapped = sum[CNT_W];
            nxt     = sum[CNT_W-1:0];
         end
      end
      wire unused_red_msb = red[CNT_W];
   end else begin : g_free
      assign wrapped = sum[CNT_W];
      assign nxt     = sum[CNT_W-1:0];
      wire unused_cfg = ^{pmode_i, period_i};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         evt_q <= 1'b0;
      end else begin
         evt_q <= 1'b0;
         if (restart_i)   cnt_q <= '0;
         else if (load_i) cnt_q <= load_val_i;
         else if (en_i) begin
            cnt_q <= nxt;
            evt_q <= wrapped && evt_en_i;
         end
      end
   end

   assign cnt_o      = cnt_q;
   assign wrap_evt_o = evt_q;
endmodule

// File: rtl/nstime_counter.sv
module nstime_counter #(
   parameter int CNT_W       = 32,
   parameter int INC_W       = 7,
   parameter int CPER_W      = 16,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 3,
   parameter bit PERIOD_WRAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [CNT_W-1:0]  count_o,
   output logic              wrap_evt_o
);
   if (INC_W > 8 || INC_W < 1) begin : g_bad_inc
      $error("INC_W must lie in 1..8");
   end
   if (CNT_W > DATA_W || CNT_W <= INC_W + 1) begin : g_bad_cnt
      $error("CNT_W must fit the data bus and exceed INC_W+1");
   end
   if (CPER_W > DATA_W || ADDR_W < 3 || DATA_W < 16) begin : g_bad_bus
      $error("bus too narrow for the register layout");
   end

   logic              en_w, pmode_w, evt_en_w, restart_w, load_w, hit_w, adv_w;
   logic [CNT_W-1:0]  period_w, cnt_w;
   logic [CPER_W-1:0] cper_w;
   logic [INC_W-1:0]  ninc_w, cinc_w, step_w;

   tc_regs #(.CNT_W(CNT_W), .INC_W(INC_W), .CPER_W(CPER_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W))
   regs_i (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
      .cnt_i(cnt_w), .rdata(bus_rdata), .en_o(en_w), .pmode_o(pmode_w),
      .evt_en_o(evt_en_w), .period_o(period_w), .cper_o(cper_w), .ninc_o(ninc_w),
      .cinc_o(cinc_w), .restart_o(restart_w), .load_o(load_w)
   );

   assign adv_w = en_w && !restart_w && !load_w;

   tc_corr #(.CPER_W(CPER_W)) corr_i (
      .clk(clk), .rst_n(rst_n), .adv_i(adv_w), .restart_i(restart_w),
      .cper_i(cper_w), .cinc_nz_i(cinc_w != '0), .hit_o(hit_w)
   );

   assign step_w = hit_w ? cinc_w : ninc_w;

   tc_accum #(.CNT_W(CNT_W), .INC_W(INC_W), .PERIOD_WRAP(PERIOD_WRAP)) accum_i (
      .clk(clk), .rst_n(rst_n), .en_i(en_w), .restart_i(restart_w), .load_i(load_w),
      .load_val_i(bus_wdata[CNT_W-1:0]), .pmode_i(pmode_w), .period_i(period_w),
      .evt_en_i(evt_en_w), .step_i(step_w), .cnt_o(cnt_w), .wrap_evt_o(wrap_evt_o)
   );

   assign count_o = cnt_w;
endmodule

// File: rtl/nstime_counter_chk.sv
module nstime_counter_chk
   import tc_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              we,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [CNT_W-1:0]  count,
   input logic              evt,
   input logic              en,
   input logic              evt_en
);
   logic wr_ctrl, wr_time;
   assign wr_ctrl = we && (addr == ADDR_W'(TC_CTRL));
   assign wr_time = we && (addr == ADDR_W'(TC_TIME));

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !wr_time && !(wr_ctrl && wdata[CB_RESTART])) |=> $stable(count)); // R2

   AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wdata[CB_RESTART]) |=> (count == '0)); // R8

   AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_time |=> (count == $past(wdata[CNT_W-1:0]))); // R10

   AST_EVT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      evt |-> $past(evt_en)); // R7

   AST_EVT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      evt |-> $past(en)); // R7
endmodule

bind nstime_counter nstime_counter_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
   .count(count_o), .evt(wrap_evt_o), .en(en_w), .evt_en(evt_en_w)
);

// File: tb/nstime_counter_tb_top.sv
`timescale 1ns/1ps
module nstime_counter_tb_top;
   localparam int CNT_W = 32, INC_W = 7, CPER_W = 16, DATA_W = 32, ADDR_W = 3;

   logic              clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic [CNT_W-1:0]  count_o;
   logic              wrap_evt_o;

   int n_chk = 0, n_err = 0;
   logic [31:0] last_rd;

   nstime_counter dut_i (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count_o(count_o), .wrap_evt_o(wrap_evt_o));

   always #4 clk = ~clk;

   // reference model state
   logic        m_en = 0, m_evt = 0, m_pend = 0, m_evout = 0;
   logic [1:0]  m_mode = 0;
   logic [31:0] m_per = 0, m_cnt = 0, m_snap = 0;
   logic [15:0] m_cper = 0, m_cc = 0;
   logic [6:0]  m_ninc = 0, m_cinc = 0;

   function automatic logic [31:0] m_read(input logic [2:0] a);
      logic [31:0] r = '0;
      case (a)
         3'd0: begin r[0] = m_en; r[5:4] = m_mode; r[7] = m_evt; r[11] = m_pend; end
         3'd1: r = m_snap;
         3'd2: r = m_per;
         3'd3: r[15:0] = m_cper;
         3'd4: begin r[6:0] = m_ninc; r[14:8] = m_cinc; end
         default: r = '0;
      endcase
      return r;
   endfunction

   task automatic m_step(input logic we, input logic [2:0] a, input logic [31:0] d);
      logic rs, ld, adv, act, hit, wr;
      logic [6:0] st;
      logic [32:0] sum;
      logic [31:0] nx;
      rs  = we && a == 3'd0 && d[9];
      ld  = we && a == 3'd1;
      adv = m_en && !rs && !ld;
      act = (m_cper != 0) && (m_cinc != 0);
      hit = adv && act && (m_cc == m_cper);
      st  = hit ? m_cinc : m_ninc;
      sum = {1'b0, m_cnt} + {26'd0, st};
      if (m_mode == 2'b11 && m_per != 0) begin
         wr = sum >= {1'b0, m_per};
         nx = wr ? 32'(sum - {1'b0, m_per}) : sum[31:0];
      end else begin
         wr = sum[32];
         nx = sum[31:0];
      end
      m_evout = adv && wr && m_evt;
      if (m_pend) m_snap = m_cnt;
      m_pend = we && a == 3'd0 && d[11];
      if (rs || !act) m_cc = 0;
      else if (adv) m_cc = hit ? 16'd0 : m_cc + 16'd1;
      if (rs) m_cnt = 0;
      else if (ld) m_cnt = d;
      else if (adv) m_cnt = nx;
      if (we) case (a)
         3'd0: begin m_en = d[0]; m_mode = d[5:4]; m_evt = d[7]; end
         3'd2: m_per = d;
         3'd3: m_cper = d[15:0];
         3'd4: begin m_ninc = d[6:0]; m_cinc = d[14:8]; end
         default: ;
      endcase
   endtask

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one bus cycle: starts and ends just after a falling edge
   task automatic cyc(input logic we, input logic [2:0] a, input logic [31:0] d, input string tag);
      logic [31:0] e;
      bus_we = we; bus_addr = a; bus_wdata = d;
      #1;
      last_rd = bus_rdata;
      e = m_read(a);
      chk(last_rd == e, {tag, " R12 read"}, last_rd, e);
      @(posedge clk);
      m_step(we, a, d);
      @(negedge clk);
      bus_we = 1'b0;
      chk(count_o == m_cnt, {tag, " count"}, count_o, m_cnt);
      chk(wrap_evt_o == m_evout, {tag, " R7 event"}, {31'd0, wrap_evt_o}, {31'd0, m_evout});
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(1'b0, 3'(i % 5), 32'd0, tag);
   endtask

   initial begin
      #(8 * 200000);
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(count_o == 0, "R1 reset count", count_o, 0);
      chk(wrap_evt_o == 0, "R1 reset event", {31'd0, wrap_evt_o}, 0);
      idle(5, "R1 reset regs");

      // R2 hold and nominal step, R4 correction off (period 0)
      cyc(1, 3'd4, 32'h0908, "R12 inc");
      cyc(1, 3'd0, 32'h0, "R2 off");
      idle(4, "R2 hold");
      chk(count_o == 0, "R2 hold", count_o, 0);
      cyc(1, 3'd0, 32'h1, "R2 enable");
      idle(10, "R2 R4 nominal");
      chk(count_o == 80, "R2 nominal steps", count_o, 80);
      // R3 correction every 4th step
      cyc(1, 3'd3, 32'd3, "R3 cper");
      idle(8, "R3 corr");
      chk(count_o == 154, "R3 correction cadence", count_o, 154);
      // R4 correction increment zero disables it
      cyc(1, 3'd4, 32'h0008, "R4 cinc0");
      idle(6, "R4 off");
      chk(count_o == 210, "R4 disabled correction", count_o, 210);

      // R6 free-mode wrap with event, R10 load
      cyc(1, 3'd0, 32'h81, "R6 ctrl");
      cyc(1, 3'd1, 32'hFFFF_FFF0, "R10 load");
      chk(count_o == 32'hFFFF_FFF0, "R10 loaded value", count_o, 32'hFFFF_FFF0);
      idle(1, "R6 pre");
      chk(count_o == 32'hFFFF_FFF8, "R6 before wrap", count_o, 32'hFFFF_FFF8);
      idle(1, "R6 wrap");
      chk(count_o == 0 && wrap_evt_o, "R6 R7 full-width wrap", count_o, 0);
      idle(1, "R6 post");
      chk(count_o == 8 && !wrap_evt_o, "R7 single pulse", count_o, 8);

      // R5 period wrap with event, then without
      cyc(1, 3'd2, 32'd100, "R5 per");
      cyc(1, 3'd0, 32'hB1, "R5 ctrl");
      cyc(1, 3'd1, 32'd90, "R5 load");
      idle(2, "R5 fold");
      chk(count_o == 6 && wrap_evt_o, "R5 fold at period", count_o, 6);
      cyc(1, 3'd0, 32'h31, "R7 evt off");
      cyc(1, 3'd1, 32'd95, "R7 load");
      idle(1, "R7 gated");
      chk(count_o == 3 && !wrap_evt_o, "R7 event gated off", count_o, 3);

      // R8 restart, R9 capture
      cyc(1, 3'd0, 32'h231, "R8 restart");
      chk(count_o == 0, "R8 restart zero", count_o, 0);
      cyc(1, 3'd0, 32'h831, "R9 capture");
      cyc(0, 3'd0, 32'h0, "R9 pending");
      chk(last_rd[11] == 1'b1 && last_rd[9] == 1'b0, "R9 R8 ctrl readback", last_rd, 32'h831);
      cyc(0, 3'd1, 32'h0, "R9 snapshot");
      chk(last_rd == 32'd8, "R9 snapshot value", last_rd, 8);
      cyc(0, 3'd0, 32'h0, "R9 cleared");
      chk(last_rd[11] == 1'b0, "R9 self clear", last_rd, 32'h31);

      // constrained random: R3 R5 R11 interplay
      for (int s = 0; s < 30; s++) begin
         logic [31:0] cfg;
         cyc(1, 3'd4, {17'd0, 7'($urandom_range(0, 127)), 1'b0, 7'($urandom_range(1, 127))}, "R3 rnd inc");
         cyc(1, 3'd3, 32'($urandom_range(0, 7)), "R3 rnd cper");
         cyc(1, 3'd2, ($urandom_range(0, 3) == 0) ? 32'd0 : 32'($urandom_range(50, 2000)), "R5 rnd per");
         cfg = 32'h1 | (($urandom_range(0, 3) != 0) ? 32'h30 : 32'h0) | (32'($urandom_range(0, 1)) << 7);
         cyc(1, 3'd0, cfg, "R5 rnd ctrl");
         for (int i = 0; i < 150; i++) begin
            int r = $urandom_range(0, 59);
            if (r == 0)      cyc(1, 3'd0, cfg | 32'h200, "R8 R11 rnd restart");
            else if (r == 1) cyc(1, 3'd0, cfg | 32'h800, "R9 rnd capture");
            else if (r == 2) cyc(1, 3'd1, 32'($urandom_range(0, 2500)), "R10 rnd load");
            else             cyc(0, 3'($urandom_range(0, 5)), 32'd0, "R3 R5 R11 rnd run");
         end
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule